// File: doc/BRIEF.md
# Program Memory Width Bridge

The bridge joins a 16-bit register data path to a program store whose words are 24 bits wide. A register move into program memory places the 16-bit operand in the low part of the word. The top byte comes from a side register called the extension latch. A move out of program memory hands the low 16 bits to the destination register and drops the top byte into the extension latch. Full 24-bit words can therefore be copied through the narrow path, one byte of side state at a time.

Each move is a one-cycle request. The bridge drives the program-memory port in the same cycle, and the acknowledge follows one cycle later. The program store is synchronous: read data is valid in the acknowledge cycle, and the extension latch captures the top byte on the edge that ends that cycle. A host port loads and reads the extension latch directly. A host load beats a read capture on the same edge. A write move always uses the byte the latch holds once the current cycle's updates are applied, so back-to-back traffic follows program order.

Top module: `pmem_width_bridge`

## Requirements
- R1: After reset, hx_rdata reads 0, mv_ack is 0 and pm_en is 0.
- R2: In a cycle with mv_req=1 and mv_wr=1, pm_en=1, pm_we=1, pm_addr equals mv_addr and pm_wdata[15:0] equals mv_wdata.
- R3: For a write move, pm_wdata[23:16] equals the extension latch's low byte after this cycle's update. A host load in the same cycle supplies hx_wdata[7:0]. Otherwise, a read completing in the same cycle supplies pm_rdata[23:16]. Otherwise the stored byte is used.
- R4: In a cycle with mv_req=1 and mv_wr=0, pm_en=1, pm_we=0 and pm_addr equals mv_addr.
- R5: mv_ack is 1 exactly in the cycle after each cycle with mv_req=1, and 0 in every other cycle.
- R6: In the acknowledge cycle of a read move, mv_rdata equals pm_rdata[15:0]. In every other cycle mv_rdata is 0.
- R7: On the clock edge that ends a read move's acknowledge cycle, the latch low byte takes pm_rdata[23:16], unless R9 applies.
- R8: hx_wr=1 loads hx_wdata[7:0] into the latch low byte and ignores hx_wdata[15:8]. hx_rdata is {8'h00, latch low byte}.
- R9: When a host load and a read capture fall on the same edge, the host value is kept.
- R10: Write moves and idle cycles leave the extension latch unchanged.
- R11: With mv_req=0, pm_en and pm_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mv_req | input | 1 | Move request, one cycle |
| mv_wr | input | 1 | 1 = move into program memory, 0 = move out |
| mv_addr | input | 16 | Program word address |
| mv_wdata | input | 16 | Register operand for a write move |
| mv_ack | output | 1 | Move acknowledge, one cycle after the request |
| mv_rdata | output | 16 | Low 16 bits of a read word, valid with the acknowledge |
| pm_en | output | 1 | Program memory access enable |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | 16 | Program memory address |
| pm_wdata | output | 24 | Program memory write word |
| pm_rdata | input | 24 | Program memory read word, one cycle after pm_en |
| hx_wr | input | 1 | Host load of the extension latch |
| hx_wdata | input | 16 | Host load value; only bits 7:0 are used |
| hx_rdata | output | 16 | Extension latch value, upper byte zero |

## Verification
The hardest case to reach is a single cycle in which a read is completing, a host load arrives, and a new write move is issued. In that cycle the write word must carry the host byte, and the captured byte must be discarded. Directed sequences issue a read immediately followed by a write, and a read immediately followed by a host load with and without a write. The random stream is weighted so that reads, writes and host loads land back to back often. A bench model of the latch then predicts each write word and each latch readback.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } pmb_op_e;

    function automatic pmb_op_e decode_op(input logic req, input logic wr);
        if (!req)   return OP_IDLE;
        else if (wr) return OP_WRITE;
        else        return OP_READ;
    endfunction

endpackage

// File: rtl/pmb_req_decode.sv
module pmb_req_decode
    import pmb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PWORD_W = 24,
    parameter int ADDR_W  = 16,
    localparam int XB     = PWORD_W - DATA_W
) (
    input  logic               mv_req,
    input  logic               mv_wr,
    input  logic [ADDR_W-1:0]  mv_addr,
    input  logic [DATA_W-1:0]  mv_wdata,
    input  logic [XB-1:0]      fwd_byte,
    output pmb_op_e            op,
    output logic               pm_en,
    output logic               pm_we,
    output logic [ADDR_W-1:0]  pm_addr,
    output logic [PWORD_W-1:0] pm_wdata
);

    always_comb begin
        op       = decode_op(mv_req, mv_wr);
        pm_en    = (op != OP_IDLE);
        pm_we    = (op == OP_WRITE);
        pm_addr  = mv_addr;
        pm_wdata = {fwd_byte, mv_wdata};
    end

endmodule

// File: rtl/pmb_ext_reg.sv
module pmb_ext_reg #(
    parameter int DATA_W  = 16,
    parameter int PWORD_W = 24,
    localparam int XB     = PWORD_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hx_wr,
    input  logic [XB-1:0]     hx_byte,
    input  logic              cap_en,
    input  logic [XB-1:0]     cap_byte,
    output logic [XB-1:0]     ext_next,
    output logic [DATA_W-1:0] hx_rdata
);

    typedef struct packed {
        logic [XB-1:0] ext;
    } ext_state_t;

    ext_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hx_wr)
            st_d.ext = hx_byte;
        else if (cap_en)
            st_d.ext = cap_byte;
        ext_next = st_d.ext;
        hx_rdata = {{(DATA_W-XB){1'b0}}, st_q.ext};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pmb_rsp_track.sv
module pmb_rsp_track
    import pmb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pmb_op_e           op,
    input  logic [DATA_W-1:0] rd_low,
    output logic              ack,
    output logic              rd_done,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic ack;
        logic rd;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    always_comb begin
        st_d.ack = (op != OP_IDLE);
        st_d.rd  = (op == OP_READ);
        ack      = st_q.ack;
        rd_done  = st_q.rd;
        rdata    = st_q.rd ? rd_low : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pmem_width_bridge.sv
module pmem_width_bridge
    import pmb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PWORD_W = 24,
    parameter int ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mv_req,
    input  logic               mv_wr,
    input  logic [ADDR_W-1:0]  mv_addr,
    input  logic [DATA_W-1:0]  mv_wdata,
    output logic               mv_ack,
    output logic [DATA_W-1:0]  mv_rdata,
    output logic               pm_en,
    output logic               pm_we,
    output logic [ADDR_W-1:0]  pm_addr,
    output logic [PWORD_W-1:0] pm_wdata,
    input  logic [PWORD_W-1:0] pm_rdata,
    input  logic               hx_wr,
    input  logic [DATA_W-1:0]  hx_wdata,
    output logic [DATA_W-1:0]  hx_rdata
);

    localparam int XB = PWORD_W - DATA_W;

    pmb_op_e       op;
    logic          rd_done;
    logic [XB-1:0] ext_next;
    logic          unused_hx_hi;

    assign unused_hx_hi = ^hx_wdata[DATA_W-1:XB];

    pmb_req_decode #(
        .DATA_W (DATA_W),
        .PWORD_W(PWORD_W),
        .ADDR_W (ADDR_W)
    ) u_req (
        .mv_req  (mv_req),
        .mv_wr   (mv_wr),
        .mv_addr (mv_addr),
        .mv_wdata(mv_wdata),
        .fwd_byte(ext_next),
        .op      (op),
        .pm_en   (pm_en),
        .pm_we   (pm_we),
        .pm_addr (pm_addr),
        .pm_wdata(pm_wdata)
    );

    pmb_ext_reg #(
        .DATA_W (DATA_W),
        .PWORD_W(PWORD_W)
    ) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .hx_wr   (hx_wr),
        .hx_byte (hx_wdata[XB-1:0]),
        .cap_en  (rd_done),
        .cap_byte(pm_rdata[PWORD_W-1:DATA_W]),
        .ext_next(ext_next),
        .hx_rdata(hx_rdata)
    );

    pmb_rsp_track #(
        .DATA_W(DATA_W)
    ) u_rsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .rd_low (pm_rdata[DATA_W-1:0]),
        .ack    (mv_ack),
        .rd_done(rd_done),
        .rdata  (mv_rdata)
    );

endmodule

// File: rtl/pmb_checker.sv
module pmb_checker #(
    parameter int DATA_W  = 16,
    parameter int PWORD_W = 24,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mv_req,
    input logic               mv_wr,
    input logic [ADDR_W-1:0]  mv_addr,
    input logic [DATA_W-1:0]  mv_wdata,
    input logic               mv_ack,
    input logic [DATA_W-1:0]  mv_rdata,
    input logic               pm_en,
    input logic               pm_we,
    input logic [ADDR_W-1:0]  pm_addr,
    input logic [PWORD_W-1:0] pm_wdata,
    input logic [PWORD_W-1:0] pm_rdata,
    input logic               hx_wr,
    input logic [DATA_W-1:0]  hx_wdata,
    input logic [DATA_W-1:0]  hx_rdata
);

    localparam int XB = PWORD_W - DATA_W;

    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_wr) |-> (pm_en && pm_we && pm_addr == mv_addr && pm_wdata[DATA_W-1:0] == mv_wdata)); // R2

    AST_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_wr) |-> (pm_en && !pm_we && pm_addr == mv_addr)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_req |-> (!pm_en && !pm_we)); // R11

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |=> mv_ack); // R5

    AST_ACK_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_req |=> !mv_ack); // R5

    AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_ack && $past(mv_req && !mv_wr)) |-> (mv_rdata == pm_rdata[DATA_W-1:0])); // R6

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mv_ack) && $past(mv_req && !mv_wr, 2) && !$past(hx_wr))
        |-> (hx_rdata[XB-1:0] == $past(pm_rdata[PWORD_W-1:DATA_W]))); // R7

    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hx_wr) |-> (hx_rdata == {{(DATA_W-XB){1'b0}}, $past(hx_wdata[XB-1:0])})); // R8 R9

    AST_WRITE_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_wr && !hx_wr && !mv_ack) |=> $stable(hx_rdata)); // R10

endmodule

bind pmem_width_bridge pmb_checker #(
    .DATA_W (DATA_W),
    .PWORD_W(PWORD_W),
    .ADDR_W (ADDR_W)
) u_pmb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mv_req  (mv_req),
    .mv_wr   (mv_wr),
    .mv_addr (mv_addr),
    .mv_wdata(mv_wdata),
    .mv_ack  (mv_ack),
    .mv_rdata(mv_rdata),
    .pm_en   (pm_en),
    .pm_we   (pm_we),
    .pm_addr (pm_addr),
    .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata),
    .hx_wr   (hx_wr),
    .hx_wdata(hx_wdata),
    .hx_rdata(hx_rdata)
);

// File: tb/pmem_width_bridge_bench.sv
`timescale 1ns/1ps
module pmem_width_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mv_req = 1'b0, mv_wr = 1'b0;
    logic [15:0] mv_addr = '0, mv_wdata = '0;
    logic        mv_ack;
    logic [15:0] mv_rdata;
    logic        pm_en, pm_we;
    logic [15:0] pm_addr;
    logic [23:0] pm_wdata;
    logic [23:0] pm_rdata;
    logic        hx_wr = 1'b0;
    logic [15:0] hx_wdata = '0;
    logic [15:0] hx_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] mem [0:63];

    // bench model
    logic [7:0]  m_ext = 8'h00;
    logic        m_ack = 1'b0;
    logic        m_rd  = 1'b0;
    logic [23:0] m_rdv = '0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    pmem_width_bridge u_pmem_width_bridge (
        .clk(clk), .rst_n(rst_n),
        .mv_req(mv_req), .mv_wr(mv_wr), .mv_addr(mv_addr), .mv_wdata(mv_wdata),
        .mv_ack(mv_ack), .mv_rdata(mv_rdata),
        .pm_en(pm_en), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .pm_rdata(pm_rdata),
        .hx_wr(hx_wr), .hx_wdata(hx_wdata), .hx_rdata(hx_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pm_rdata <= '0;
        else if (pm_en) begin
            if (pm_we) mem[pm_addr[5:0]] <= pm_wdata;
            else       pm_rdata <= mem[pm_addr[5:0]];
        end
    end

    function automatic logic [7:0] next_ext(logic hw, logic [15:0] hd, logic rd, logic [23:0] rv, logic [7:0] cur);
        if (hw)      return hd[7:0];
        else if (rd) return rv[23:16];
        else         return cur;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic req, logic wr, logic [15:0] addr, logic [15:0] wd,
                        logic hw, logic [15:0] hd);
        logic [7:0]  nx;
        logic [23:0] rv_new;
        @(negedge clk);
        mv_req = req; mv_wr = wr; mv_addr = addr; mv_wdata = wd;
        hx_wr = hw; hx_wdata = hd;
        #2;
        nx = next_ext(hw, hd, m_rd, pm_rdata, m_ext);
        chk(m_tag, {16'h0, hx_rdata}, {24'h0, m_ext});
        chk("R5", {31'h0, mv_ack}, {31'h0, m_ack});
        chk("R6", {16'h0, mv_rdata}, m_rd ? {16'h0, m_rdv[15:0]} : 32'h0);
        if (m_rd) chk("R6", {16'h0, mv_rdata}, {16'h0, pm_rdata[15:0]});
        if (!req) begin
            chk("R11", {30'h0, pm_en, pm_we}, 32'h0);
        end else if (wr) begin
            chk("R2", {15'h0, pm_en, pm_we, pm_addr}, {15'h0, 2'b11, addr});
            chk("R2", {16'h0, pm_wdata[15:0]}, {16'h0, wd});
            chk("R3", {24'h0, pm_wdata[23:16]}, {24'h0, nx});
        end else begin
            chk("R4", {15'h0, pm_en, pm_we, pm_addr}, {15'h0, 2'b10, addr});
        end
        rv_new = mem[addr[5:0]];
        if (hw && m_rd)      m_tag = "R9";
        else if (hw)         m_tag = "R8";
        else if (m_rd)       m_tag = "R7";
        else                 m_tag = "R10";
        @(posedge clk);
        m_ext = nx;
        m_ack = req;
        m_rd  = req && !wr;
        m_rdv = rv_new;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = 24'($urandom);
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {16'h0, hx_rdata}, 32'h0);
        chk("R1", {30'h0, mv_ack, pm_en}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: upper host byte ignored
        step(0, 0, 0, 0, 1, 16'hABCD);
        // write uses stored byte
        step(1, 1, 16'd3, 16'h1234, 0, 0);
        // R3: host load and write in same cycle forward
        step(1, 1, 16'd4, 16'h5678, 1, 16'h7F5A);
        // full round trip, read then write back to back (forwarded capture)
        step(1, 0, 16'd3, 0, 0, 0);
        step(1, 1, 16'd5, 16'h0F0F, 0, 0);
        // read then host load collision (R9) plus a write
        step(1, 0, 16'd4, 0, 0, 0);
        step(1, 1, 16'd6, 16'hAAAA, 1, 16'h0011);
        // read then idle capture (R7)
        step(1, 0, 16'd5, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        for (int n = 0; n < 4000; n++) begin
            logic r, w, h;
            r = ($urandom % 4) != 0;
            w = ($urandom % 2) != 0;
            h = ($urandom % 4) == 0;
            step(r, w, 16'($urandom), 16'($urandom), h, 16'($urandom));
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule